// File: doc/BRIEF.md
# Selectable Square-Wave Output Generator

This block turns the 32768 Hz crystal clock of a real-time clock into a square wave at one of four rates chosen by a two-bit select field. A prescaler counts crystal cycles. Three of its bits serve as the slower rates, and the clock itself, gated, serves as the fastest. The slowest rate is one cycle per second. Its phase is set again by every time-register write: the write clears the prescaler, so each second of output lines up with the moment the time was loaded.

The wave goes to an output pin that is shared with an interrupt line. A mode bit routes either the wave or the active-low interrupt level to that pin. A stop bit freezes the prescaler and holds the wave high, which models the oscillator being switched off to save power.

Top module: `sqw_fout_gen`

## Requirements
- R1: While reset is asserted, the select register holds its default of 2'b11, so `wave_out` follows `clk`: high in the high phase and low in the low phase.
- R2: With `rate_sel` = 2'b11 and the oscillator running, `wave_out` equals `clk`.
- R3: With `rate_sel` = 2'b10, `wave_out` is bit 1 of the prescaler count. The period is 4 crystal cycles, low for 2 and high for 2, starting low after a clear.
- R4: With `rate_sel` = 2'b01, `wave_out` is bit 2 of the prescaler count. The period is 8 cycles, with 4 low then 4 high.
- R5: With `rate_sel` = 2'b00, `wave_out` is bit 14 of the prescaler count. The period is 32768 cycles: low for the first 16384 counts after a clear, then high for the next 16384.
- R6: A one-cycle `time_wr` pulse clears the prescaler to zero at the next edge. The slow output is low again from that edge, and its next falling edge comes a full period later.
- R7: A new `rate_sel` value takes effect at the next clock edge and does not reset the prescaler. The new tap shows the bit of the count as it continues.
- R8: While `osc_stop` is 1, the prescaler keeps its value and `wave_out` and `pin_out` stay high, starting at the first edge that samples the stop. When `osc_stop` returns to 0, counting resumes from the held value.
- R9: With `pin_irq_mode` = 1, `pin_out` equals `irq_lvl_n` whatever the wave is doing. With `pin_irq_mode` = 0, `pin_out` equals `wave_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, nominally 32768 Hz |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_stop | input | 1 | 1 stops the oscillator and holds the output high; 0 runs it |
| rate_sel | input | 2 | Rate select: 11 full, 10 quarter, 01 eighth, 00 one per second |
| time_wr | input | 1 | One-cycle strobe from a time-register write; clears the prescaler |
| pin_irq_mode | input | 1 | 1 routes the interrupt level to the pin; 0 routes the wave |
| irq_lvl_n | input | 1 | Active-low interrupt level from the alarm logic |
| wave_out | output | 1 | Selected square wave before the pin multiplexer |
| pin_out | output | 1 | Shared-pin value |

## Verification
The bench counts crystal edges from every clear on its own and derives each expected level by shifting that count. A tap taken from the wrong prescaler bit, or a count that is off by one, therefore fails within a few cycles. Three corner cases get their own tests, each aimed at a specific bug:
- A rate change in the middle of a run: a design that cleared the counter there would come out of phase.
- A stop followed by a restart: a design that let one extra count slip through, or that lost the held value, would shift every later edge.
- A time write in the high half of the one-second wave: a design that ignored the write would stay high instead of dropping at once.

The full-rate mode and the shared pin are sampled in both clock phases. A multiplexer that leaks the wave into interrupt mode is then caught.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW    = 2'b00,
    RATE_EIGHTH  = 2'b01,
    RATE_QUARTER = 2'b10,
    RATE_FULL    = 2'b11
  } rate_e;

  // Picks one of the candidate levels according to the rate code.
  function automatic logic pick_level(input rate_e rate, input logic full,
                                      input logic quarter, input logic eighth,
                                      input logic slow);
    case (rate)
      RATE_FULL:    pick_level = full;
      RATE_QUARTER: pick_level = quarter;
      RATE_EIGHTH:  pick_level = eighth;
      default:      pick_level = slow;
    endcase
  endfunction

  // Next prescaler value: a clear wins, a stop holds, otherwise count up.
  function automatic logic [31:0] next_count(input logic [31:0] cur, input logic clr,
                                             input logic hold);
    if (clr)       next_count = '0;
    else if (hold) next_count = cur;
    else           next_count = cur + 32'd1;
  endfunction

endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  output logic [DIV_W-1:0] count
);
  import sqw_pkg::*;

  logic [31:0] nxt_w;

  always_comb nxt_w = next_count(32'(count), clr, hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt_w[DIV_W-1:0];
  end
endmodule

// File: rtl/sqw_tap_sel.sv
module sqw_tap_sel #(
  parameter int         DIV_W    = 15,
  parameter int         TAP_QTR  = 1,
  parameter int         TAP_8TH  = 2,
  parameter int         TAP_SLOW = 14,
  parameter logic [1:0] RST_SEL  = 2'b11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_sel,
  input  logic             osc_stop,
  input  logic [DIV_W-1:0] count,
  output logic [1:0]       sel_q,
  output logic             off_q,
  output logic             wave
);
  import sqw_pkg::*;

  logic tap_qtr, tap_8th, tap_slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= RST_SEL;
      off_q <= 1'b0;
    end else begin
      sel_q <= rate_sel;
      off_q <= osc_stop;
    end
  end

  always_comb begin
    tap_qtr  = count[TAP_QTR];
    tap_8th  = count[TAP_8TH];
    tap_slow = count[TAP_SLOW];
    if (off_q) wave = 1'b1;
    else       wave = pick_level(rate_e'(sel_q), clk, tap_qtr, tap_8th, tap_slow);
  end
endmodule

// File: rtl/sqw_pin_mux.sv
module sqw_pin_mux (
  input  logic irq_mode,
  input  logic irq_n,
  input  logic wave,
  output logic pin
);
  always_comb pin = irq_mode ? irq_n : wave;
endmodule

// File: rtl/sqw_fout_gen.sv
module sqw_fout_gen #(
  parameter int         DIV_W    = 15,
  parameter int         TAP_QTR  = 1,
  parameter int         TAP_8TH  = 2,
  parameter int         TAP_SLOW = DIV_W - 1,
  parameter logic [1:0] RST_SEL  = 2'b11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_stop,
  input  logic [1:0] rate_sel,
  input  logic       time_wr,
  input  logic       pin_irq_mode,
  input  logic       irq_lvl_n,
  output logic       wave_out,
  output logic       pin_out
);
  // Internal events brought out by name for the checker.
  logic [DIV_W-1:0] pre_cnt;
  logic [1:0]       sel_q;
  logic             off_q;

  sqw_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (time_wr),
    .hold  (osc_stop),
    .count (pre_cnt)
  );

  sqw_tap_sel #(
    .DIV_W(DIV_W), .TAP_QTR(TAP_QTR), .TAP_8TH(TAP_8TH),
    .TAP_SLOW(TAP_SLOW), .RST_SEL(RST_SEL)
  ) u_tap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .osc_stop (osc_stop),
    .count    (pre_cnt),
    .sel_q    (sel_q),
    .off_q    (off_q),
    .wave     (wave_out)
  );

  sqw_pin_mux u_pin (
    .irq_mode (pin_irq_mode),
    .irq_n    (irq_lvl_n),
    .wave     (wave_out),
    .pin      (pin_out)
  );
endmodule

// File: rtl/sqw_fout_chk.sv
module sqw_fout_chk #(
  parameter int DIV_W    = 15,
  parameter int TAP_QTR  = 1,
  parameter int TAP_8TH  = 2,
  parameter int TAP_SLOW = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_stop,
  input logic             time_wr,
  input logic [DIV_W-1:0] cnt,
  input logic [1:0]       sel_q,
  input logic             off_q,
  input logic             wave_out
);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> (cnt == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !time_wr) |=> $stable(cnt));

  p_stop_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> wave_out);

  p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_stop && !time_wr) |=> (cnt == $past(cnt) + DIV_W'(1)));

  p_tap_qtr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_q && sel_q == 2'b10) |-> (wave_out == cnt[TAP_QTR]));

  p_tap_8th_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_q && sel_q == 2'b01) |-> (wave_out == cnt[TAP_8TH]));

  p_tap_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_q && sel_q == 2'b00) |-> (wave_out == cnt[TAP_SLOW]));
endmodule

bind sqw_fout_gen sqw_fout_chk #(
  .DIV_W(DIV_W), .TAP_QTR(TAP_QTR), .TAP_8TH(TAP_8TH), .TAP_SLOW(TAP_SLOW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .osc_stop (osc_stop),
  .time_wr  (time_wr),
  .cnt      (pre_cnt),
  .sel_q    (sel_q),
  .off_q    (off_q),
  .wave_out (wave_out)
);

// File: tb/sqw_fout_gen_test.sv
module sqw_fout_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_stop = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       time_wr = 1'b0;
  logic       pin_irq_mode = 1'b0;
  logic       irq_lvl_n = 1'b1;
  logic       wave_out, pin_out;

  int total = 0;
  int bad = 0;
  int n = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sqw_fout_gen uut (
    .clk(clk), .rst_n(rst_n), .osc_stop(osc_stop), .rate_sel(rate_sel),
    .time_wr(time_wr), .pin_irq_mode(pin_irq_mode), .irq_lvl_n(irq_lvl_n),
    .wave_out(wave_out), .pin_out(pin_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (count=%0d, t=%0t)", req, act, exp, n, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  // Expected level from the edge count since the last clear.
  function automatic logic expect_lvl(input logic [1:0] rate, input int cnt);
    int m;
    m = cnt % 32768;
    case (rate)
      2'b10:   expect_lvl = logic'((m >> 1) & 1);
      2'b01:   expect_lvl = logic'((m >> 2) & 1);
      default: expect_lvl = logic'((m >> 14) & 1);
    endcase
  endfunction

  task automatic clear_pre();
    time_wr = 1'b1;
    tick();
    n = 0;
    time_wr = 1'b0;
    if (rate_sel != 2'b11) chk("R6 clear", wave_out, 1'b0);
  endtask

  task automatic sweep(input string req, input logic [1:0] rate, input int cycles);
    rate_sel = rate;
    for (int i = 0; i < cycles; i++) begin
      tick();
      n++;
      if (rate == 2'b11) begin
        chk(req, wave_out, 1'b1);
        #10;
        chk(req, wave_out, 1'b0);
      end else begin
        chk(req, wave_out, expect_lvl(rate, n));
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, wave follows the clock
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #5;
      chk("R1 reset high phase", wave_out, 1'b1);
      #10;
      chk("R1 reset low phase", wave_out, 1'b0);
    end
    tick();
    rst_n = 1'b1;

    // R2: full rate
    rate_sel = 2'b11;
    clear_pre();
    sweep("R2 full", 2'b11, 16);

    // R3 and R4: the fast taps
    rate_sel = 2'b10;
    clear_pre();
    sweep("R3 quarter", 2'b10, 64);
    rate_sel = 2'b01;
    clear_pre();
    sweep("R4 eighth", 2'b01, 64);

    // R7: change the rate in mid-run, the counter keeps going
    rate_sel = 2'b01;
    clear_pre();
    sweep("R7 before", 2'b01, 5);
    sweep("R7 after change", 2'b10, 40);
    sweep("R7 back", 2'b01, 20);

    // R8: stop holds the count and drives the output high
    rate_sel = 2'b10;
    clear_pre();
    sweep("R8 run", 2'b10, 3);
    osc_stop = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R8 stopped wave", wave_out, 1'b1);
      chk("R8 stopped pin", pin_out, 1'b1);
    end
    osc_stop = 1'b0;
    sweep("R8 resume", 2'b10, 20);

    // R9: shared pin
    rate_sel = 2'b11;
    tick();
    pin_irq_mode = 1'b1;
    irq_lvl_n = 1'b0;
    #1; chk("R9 irq low", pin_out, 1'b0);
    irq_lvl_n = 1'b1;
    #1; chk("R9 irq high", pin_out, 1'b1);
    #8;
    chk("R9 irq high, clock low", pin_out, 1'b1);
    chk("R2 clock low", wave_out, 1'b0);
    pin_irq_mode = 1'b0;
    #1; chk("R9 wave on pin", pin_out, 1'b0);
    tick();
    chk("R9 wave on pin high", pin_out, 1'b1);

    // R5: one-per-second output, then R6 realign in the high half
    rate_sel = 2'b00;
    clear_pre();
    sweep("R5 slow", 2'b00, 20000);
    chk("R6 high before write", wave_out, 1'b1);
    clear_pre();
    sweep("R6 slow after write", 2'b00, 33000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule